// File: doc/BRIEF.md
# Pipelined YCbCr to RGB888 Colour Converter

This block turns one pixel per clock of 8-bit luma and chroma samples into 8-bit red, green and blue. Each sample has a programmable luma or chroma offset removed. A matrix of five unsigned coefficients, held as fractions of 1024, then produces the three colours. The luma gain is shared by all three colours. Each sum is rounded, divided by 1024 and clamped to 0..255. Pixels enter and leave through valid/ready handshakes, and any stall at the output can hold the three-stage pipeline without loss.

A small write-only register port holds the settings. It takes a 3-bit address and a 12-bit data word. Address 0 is control: bit 0 enables conversion (reset value 1) and bit 1 selects reversed output order (reset value 0). Address 1 is the luma offset, reset value 0. Address 2 is the chroma offset, reset value 128. Addresses 3 to 7 hold the gains K0..K4, with reset values 0x4A8, 0x662, 0x191, 0x341 and 0x811. The reset input is asynchronous and active low. Its release is synchronised inside the block, which takes two clocks to leave reset. Settings must be written only while no pixel is in flight.

Top module: `ycc2rgb_conv`

## Requirements
- R1: With conversion on, the block forms y = in_ch0 - luma offset, u = in_ch1 - chroma offset and v = in_ch2 - chroma offset as signed values. The reset offsets are 0 for luma and 128 for chroma.
- R2: Each colour equals floor((S + 512) / 1024), where S is K0·y + K1·v for red, K0·y - K2·u - K3·v for green and K0·y + K4·u for blue.
- R3: A rounded result below 0 gives 0, and one above 255 gives 255.
- R4: After reset the gains are K0=0x4A8, K1=0x662, K2=0x191, K3=0x341 and K4=0x811, and the control register reads conversion on with normal order.
- R5: A write with cfg_wr_en high updates the addressed register in the next cycle. The map is: 0 control, 1 luma offset (low 8 bits), 2 chroma offset (low 8 bits), 3..7 gains K0..K4 (12 bits).
- R6: With control bit 1 at 0, out_ch0/1/2 carry R/G/B. With it at 1, they carry B/G/R.
- R7: With control bit 0 at 0, out_chN equals in_chN for every N, whatever the order bit and offsets are.
- R8: Latency is three cycles. A pixel accepted at clock edge k shows on the outputs after edge k+2. While out_ready is high, in_ready is high, so one pixel passes per cycle.
- R9: While out_valid is high and out_ready low, the outputs hold still. The pipeline buffers three pixels and then drops in_ready. No pixel is lost, duplicated or reordered.
- R10: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 12 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_ch0 | input | 8 | Luma sample (R in bypass) |
| in_ch1 | input | 8 | Blue-difference chroma (G in bypass) |
| in_ch2 | input | 8 | Red-difference chroma (B in bypass) |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_ch0 | output | 8 | Red, or blue when reversed |
| out_ch1 | output | 8 | Green |
| out_ch2 | output | 8 | Blue, or red when reversed |

## Verification
The bench targets saturation at both ends. Full-scale luma overflows the sum and zero luma with low chroma goes negative. A clamp that ignores the sign would wrap these to wrong bright or dark values. Rounding is probed with random pixels and a second gain set, where truncation or round-toward-zero on negative sums would be off by one. Random and full output stalls catch a stage that drops, duplicates or alters a held pixel. The order-swap and bypass modes are also checked, since a mix-up there would place red in the blue slot or convert data meant to pass through unchanged.

// File: rtl/ycc_pkg.sv
package ycc_pkg;

  localparam int NUM_K = 5;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_LUMA   = 3'd1,
    REG_CHROMA = 3'd2,
    REG_K0     = 3'd3
  } cfg_reg_e;

  // Reset gain values in 1/1024 units
  function automatic logic [11:0] k_reset(input int idx);
    case (idx)
      0:       k_reset = 12'h4A8;
      1:       k_reset = 12'h662;
      2:       k_reset = 12'h191;
      3:       k_reset = 12'h341;
      default: k_reset = 12'h811;
    endcase
  endfunction

  // Which centred sample (0=y,1=u,2=v) feeds each gain
  function automatic int k_operand(input int idx);
    case (idx)
      0:       k_operand = 0;
      1:       k_operand = 2;
      2:       k_operand = 1;
      3:       k_operand = 2;
      default: k_operand = 1;
    endcase
  endfunction

endpackage

// File: rtl/ycc_cfg_regs.sv
module ycc_cfg_regs
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [2:0]                      addr,
  input  logic [COEF_W-1:0]               wdata,
  output logic                            conv_en,
  output logic                            rev_order,
  output logic [PIX_W-1:0]                luma_ofs,
  output logic [PIX_W-1:0]                chroma_ofs,
  output logic [NUM_K-1:0][COEF_W-1:0]    gain
);

  logic [1:0]                      ctrl_q, ctrl_d;
  logic [PIX_W-1:0]                luma_q, luma_d, chroma_q, chroma_d;
  logic [NUM_K-1:0][COEF_W-1:0]    gain_q, gain_d;

  always_comb begin
    ctrl_d   = ctrl_q;
    luma_d   = luma_q;
    chroma_d = chroma_q;
    gain_d   = gain_q;
    if (wr_en) begin
      if (addr == REG_CTRL)   ctrl_d   = wdata[1:0];
      if (addr == REG_LUMA)   luma_d   = wdata[PIX_W-1:0];
      if (addr == REG_CHROMA) chroma_d = wdata[PIX_W-1:0];
      for (int i = 0; i < NUM_K; i++) begin
        if (int'(addr) == int'(REG_K0) + i) gain_d[i] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= 2'b01;
      luma_q   <= '0;
      chroma_q <= PIX_W'(1) << (PIX_W - 1);
      for (int i = 0; i < NUM_K; i++) gain_q[i] <= COEF_W'(k_reset(i));
    end else begin
      ctrl_q   <= ctrl_d;
      luma_q   <= luma_d;
      chroma_q <= chroma_d;
      gain_q   <= gain_d;
    end
  end

  assign conv_en    = ctrl_q[0];
  assign rev_order  = ctrl_q[1];
  assign luma_ofs   = luma_q;
  assign chroma_ofs = chroma_q;
  assign gain       = gain_q;

  // R5: a gain write lands in the register one cycle later
  assert_gain_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_K0) |=> (gain_q[0] == $past(wdata)));

endmodule

// File: rtl/ycc_offset_stage.sv
module ycc_offset_stage #(
  parameter int PIX_W  = 8,
  parameter int DIFF_W = 10
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [2:0][PIX_W-1:0]        in_pix,
  input  logic [PIX_W-1:0]             luma_ofs,
  input  logic [PIX_W-1:0]             chroma_ofs,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [2:0][DIFF_W-1:0]       out_diff,
  output logic [2:0][PIX_W-1:0]        out_raw
);

  logic                   vld_q, vld_d, load;
  logic [2:0][DIFF_W-1:0] diff_q, diff_d;
  logic [2:0][PIX_W-1:0]  raw_q;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    diff_d[0] = DIFF_W'(in_pix[0]) - DIFF_W'(luma_ofs);
    diff_d[1] = DIFF_W'(in_pix[1]) - DIFF_W'(chroma_ofs);
    diff_d[2] = DIFF_W'(in_pix[2]) - DIFF_W'(chroma_ofs);
    vld_d     = load || (vld_q && !out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      diff_q <= diff_d;
      raw_q  <= in_pix;
    end
  end

  assign out_valid = vld_q;
  assign out_diff  = diff_q;
  assign out_raw   = raw_q;

  // R9: a stalled pixel stays in place
  assert_offset_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(diff_q) && $stable(raw_q)));

endmodule

// File: rtl/ycc_mult_stage.sv
module ycc_mult_stage
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int DIFF_W = 10,
  parameter int COEF_W = 12,
  parameter int PROD_W = 23
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [2:0][DIFF_W-1:0]        in_diff,
  input  logic [2:0][PIX_W-1:0]         in_raw,
  input  logic [NUM_K-1:0][COEF_W-1:0]  gain,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [NUM_K-1:0][PROD_W-1:0]  out_prod,
  output logic [2:0][PIX_W-1:0]         out_raw
);

  logic                          vld_q, vld_d, load;
  logic [NUM_K-1:0][PROD_W-1:0]  prod_d, prod_q;
  logic [2:0][PIX_W-1:0]         raw_q;

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;
  assign vld_d    = load || (vld_q && !out_ready);

  for (genvar i = 0; i < NUM_K; i++) begin : g_mul
    localparam int SEL = k_operand(i);
    logic signed [PROD_W-1:0] a_ext, b_ext;
    assign a_ext = $signed({{(PROD_W-DIFF_W){in_diff[SEL][DIFF_W-1]}}, in_diff[SEL]});
    assign b_ext = $signed({{(PROD_W-COEF_W){1'b0}}, gain[i]});
    assign prod_d[i] = a_ext * b_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      prod_q <= prod_d;
      raw_q  <= in_raw;
    end
  end

  assign out_valid = vld_q;
  assign out_prod  = prod_q;
  assign out_raw   = raw_q;

  // R9: products are not lost or altered under a stall
  assert_mult_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(prod_q)));

endmodule

// File: rtl/ycc_sum_stage.sv
module ycc_sum_stage
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int PROD_W = 23,
  parameter int FRAC_W = 10,
  parameter int SUM_W  = 25
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [NUM_K-1:0][PROD_W-1:0]  in_prod,
  input  logic [2:0][PIX_W-1:0]         in_raw,
  input  logic                          conv_en,
  input  logic                          rev_order,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [2:0][PIX_W-1:0]         out_pix
);

  logic                   vld_q, vld_d, load;
  logic [2:0][PIX_W-1:0]  pix_q, pix_d;
  logic signed [SUM_W-1:0] ext [NUM_K];
  logic signed [SUM_W-1:0] sum_r, sum_g, sum_b;
  logic [PIX_W-1:0]        col_r, col_g, col_b;

  function automatic logic [PIX_W-1:0] round_clamp(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] t;
    logic signed [SUM_W-1:0] q;
    t = s + SUM_W'(1 << (FRAC_W - 1));
    q = t >>> FRAC_W;
    if (q[SUM_W-1])               round_clamp = '0;
    else if (|q[SUM_W-2:PIX_W])   round_clamp = '1;
    else                          round_clamp = q[PIX_W-1:0];
  endfunction

  for (genvar i = 0; i < NUM_K; i++) begin : g_ext
    assign ext[i] = $signed({{(SUM_W-PROD_W){in_prod[i][PROD_W-1]}}, in_prod[i]});
  end

  assign in_ready = !vld_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    sum_r = ext[0] + ext[1];
    sum_g = ext[0] - ext[2] - ext[3];
    sum_b = ext[0] + ext[4];
    col_r = round_clamp(sum_r);
    col_g = round_clamp(sum_g);
    col_b = round_clamp(sum_b);
    if (!conv_en)       pix_d = in_raw;
    else if (rev_order) pix_d = {col_r, col_g, col_b};
    else                pix_d = {col_b, col_g, col_r};
    vld_d = load || (vld_q && !out_ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) pix_q <= pix_d;
  end

  assign out_valid = vld_q;
  assign out_pix   = pix_q;

  // R9: the output pixel holds while downstream stalls
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !out_ready) |=> (vld_q && $stable(pix_q)));

endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
  import ycc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 12,
  parameter int FRAC_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [2:0]        cfg_addr,
  input  logic [COEF_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_ch0,
  input  logic [PIX_W-1:0]  in_ch1,
  input  logic [PIX_W-1:0]  in_ch2,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PIX_W-1:0]  out_ch0,
  output logic [PIX_W-1:0]  out_ch1,
  output logic [PIX_W-1:0]  out_ch2
);

  localparam int DIFF_W = PIX_W + 2;
  localparam int PROD_W = DIFF_W + COEF_W + 1;
  localparam int SUM_W  = PROD_W + 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic                          conv_en, rev_order;
  logic [PIX_W-1:0]              luma_ofs, chroma_ofs;
  logic [NUM_K-1:0][COEF_W-1:0]  gain;

  logic                          v1, r1, v2, r2;
  logic [2:0][DIFF_W-1:0]        diff1;
  logic [2:0][PIX_W-1:0]         raw1, raw2, pix_out;
  logic [NUM_K-1:0][PROD_W-1:0]  prod2;

  ycc_cfg_regs #(.PIX_W(PIX_W), .COEF_W(COEF_W)) cfg_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .conv_en(conv_en), .rev_order(rev_order),
    .luma_ofs(luma_ofs), .chroma_ofs(chroma_ofs), .gain(gain));

  ycc_offset_stage #(.PIX_W(PIX_W), .DIFF_W(DIFF_W)) ofs_i (
    .clk(clk), .rst_n(rst_int_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix({in_ch2, in_ch1, in_ch0}), .luma_ofs(luma_ofs),
    .chroma_ofs(chroma_ofs), .out_valid(v1), .out_ready(r1),
    .out_diff(diff1), .out_raw(raw1));

  ycc_mult_stage #(.PIX_W(PIX_W), .DIFF_W(DIFF_W), .COEF_W(COEF_W),
                   .PROD_W(PROD_W)) mul_i (
    .clk(clk), .rst_n(rst_int_n), .in_valid(v1), .in_ready(r1),
    .in_diff(diff1), .in_raw(raw1), .gain(gain), .out_valid(v2),
    .out_ready(r2), .out_prod(prod2), .out_raw(raw2));

  ycc_sum_stage #(.PIX_W(PIX_W), .PROD_W(PROD_W), .FRAC_W(FRAC_W),
                  .SUM_W(SUM_W)) sum_i (
    .clk(clk), .rst_n(rst_int_n), .in_valid(v2), .in_ready(r2),
    .in_prod(prod2), .in_raw(raw2), .conv_en(conv_en),
    .rev_order(rev_order), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(pix_out));

  assign out_ch0 = pix_out[0];
  assign out_ch1 = pix_out[1];
  assign out_ch2 = pix_out[2];

  // R8: a ready sink makes the whole chain ready
  assert_full_rate_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_ready |-> in_ready);

endmodule

// File: tb/ycc2rgb_conv_tb_top.sv
module ycc2rgb_conv_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr_en;
  logic [2:0] cfg_addr;
  logic [11:0] cfg_wdata;
  logic       in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_ch0, in_ch1, in_ch2, out_ch0, out_ch1, out_ch2;

  always #2 clk = ~clk;

  ycc2rgb_conv dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_ready(in_ready),
    .in_ch0(in_ch0), .in_ch1(in_ch1), .in_ch2(in_ch2),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_ch0(out_ch0), .out_ch1(out_ch1), .out_ch2(out_ch2));

  typedef struct { int c0; int c1; int c2; } trip_t;

  int    checks = 0, errors = 0;
  string cur_req = "R10";
  bit    mon_en = 0, stall_en = 0, hold_pend = 0, done = 0;
  trip_t exp_q[$];
  trip_t held;
  int    m_conv, m_rev, m_lo, m_co;
  int    m_k[5];

  task automatic model_defaults();
    m_conv = 1; m_rev = 0; m_lo = 0; m_co = 128;
    m_k[0] = 'h4A8; m_k[1] = 'h662; m_k[2] = 'h191; m_k[3] = 'h341; m_k[4] = 'h811;
  endtask

  function automatic int rc(int s);
    int t, q;
    t = s + 512;
    q = (t >= 0) ? t / 1024 : -((-t + 1023) / 1024);
    if (q < 0) q = 0;
    if (q > 255) q = 255;
    return q;
  endfunction

  function automatic trip_t model(int a, int b, int c);
    trip_t o;
    int y, u, v, r, g, bl;
    if (m_conv == 0) begin
      o.c0 = a; o.c1 = b; o.c2 = c;
      return o;
    end
    y = a - m_lo; u = b - m_co; v = c - m_co;
    r  = rc(m_k[0]*y + m_k[1]*v);
    g  = rc(m_k[0]*y - m_k[2]*u - m_k[3]*v);
    bl = rc(m_k[0]*y + m_k[4]*u);
    if (m_rev != 0) begin o.c0 = bl; o.c1 = g; o.c2 = r; end
    else            begin o.c0 = r;  o.c1 = g; o.c2 = bl; end
    return o;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference scoreboard, evaluated half a cycle before each edge
  always @(negedge clk) begin
    if (mon_en) begin
      if (hold_pend) begin
        check("R9", "held valid", int'(out_valid), 1);
        check("R9", "held ch0", int'(out_ch0), held.c0);
        check("R9", "held ch2", int'(out_ch2), held.c2);
      end
      hold_pend = out_valid && !out_ready;
      held.c0 = out_ch0; held.c1 = out_ch1; held.c2 = out_ch2;
      if (in_valid && in_ready) exp_q.push_back(model(in_ch0, in_ch1, in_ch2));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(cur_req, "unexpected output", 1, 0);
        else begin
          trip_t e;
          e = exp_q.pop_front();
          check(cur_req, "ch0", int'(out_ch0), e.c0);
          check(cur_req, "ch1", int'(out_ch1), e.c1);
          check(cur_req, "ch2", int'(out_ch2), e.c2);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); #1;
      if (stall_en) out_ready = 1'($urandom % 2);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic do_reset();
    mon_en = 0; hold_pend = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    model_defaults();
    exp_q.delete();
    #1 mon_en = 1;
  endtask

  task automatic cfg_write(int a, int d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_addr = 3'(a); cfg_wdata = 12'(d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    case (a)
      0: begin m_conv = d & 1; m_rev = (d >> 1) & 1; end
      1: m_lo = d & 255;
      2: m_co = d & 255;
      default: m_k[a-3] = d;
    endcase
  endtask

  task automatic send(int a, int b, int c);
    @(posedge clk); #1;
    in_valid = 1'b1; in_ch0 = 8'(a); in_ch1 = 8'(b); in_ch2 = 8'(c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic send_rand(int n);
    for (int i = 0; i < n; i++)
      send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
  endtask

  initial begin
    cfg_wr_en = 0; cfg_addr = 0; cfg_wdata = 0;
    in_valid = 0; in_ch0 = 0; in_ch1 = 0; in_ch2 = 0; out_ready = 1;
    do_reset();

    @(negedge clk);
    check("R10", "out_valid after reset", int'(out_valid), 0);
    check("R10", "in_ready after reset", int'(in_ready), 1);

    // Defaults: black, white, grey, primaries
    cur_req = "R1";
    send(0, 128, 128);  send(255, 128, 128); send(128, 128, 128);
    send(16, 128, 128);
    drain();
    cur_req = "R2";
    send(81, 90, 240);  send(145, 54, 34);   send(41, 240, 110);
    send(170, 166, 16); send(106, 202, 222); send(210, 16, 146);
    send_rand(40);
    drain();

    cur_req = "R3";
    send(255, 255, 255); send(0, 0, 0); send(255, 0, 255); send(0, 255, 0);
    send(255, 128, 255); send(0, 128, 0);
    drain();

    // Latency and full rate
    begin
      int n;
      cur_req = "R8";
      @(posedge clk); #1;
      in_valid = 1; in_ch0 = 8'd90; in_ch1 = 8'd100; in_ch2 = 8'd200;
      @(posedge clk); #1;
      in_valid = 0;
      n = 0;
      do begin @(negedge clk); n++; end while (!out_valid && n < 10);
      check("R8", "latency cycles", n, 3);
      drain();
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        check("R8", "in_ready at full rate", int'(in_ready), 1);
        send($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
      end
      drain();
    end

    // Full stall: three pixels buffered, then back-pressure
    cur_req = "R9";
    @(posedge clk); #1 out_ready = 0;
    send(10, 20, 30); send(200, 60, 180); send(77, 140, 99);
    @(posedge clk); #1;
    in_valid = 1; in_ch0 = 8'd5; in_ch1 = 8'd250; in_ch2 = 8'd128;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R9", "in_ready when full", int'(in_ready), 0);
    end
    @(posedge clk); #1 out_ready = 1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1 in_valid = 0;
    drain();

    // Random back-pressure
    stall_en = 1;
    send_rand(60);
    stall_en = 0;
    @(posedge clk); #1 out_ready = 1;
    drain();

    // Reversed order
    cur_req = "R6";
    cfg_write(0, 3);
    send(81, 90, 240); send(41, 240, 110);
    send_rand(10);
    drain();

    // Bypass ignores order and offsets
    cur_req = "R7";
    cfg_write(0, 2);
    cfg_write(1, 40);
    send(81, 90, 240); send(0, 255, 7);
    send_rand(10);
    drain();

    // Custom programming
    cur_req = "R5";
    cfg_write(0, 1); cfg_write(1, 16); cfg_write(2, 120);
    cfg_write(3, 'h200); cfg_write(4, 'h300); cfg_write(5, 'h080);
    cfg_write(6, 'h100); cfg_write(7, 'hFFF);
    send(16, 120, 120); send(235, 240, 16); send(100, 30, 200);
    send_rand(20);
    drain();

    // Reset restores default programming
    cur_req = "R4";
    do_reset();
    send(81, 90, 240); send(145, 54, 34); send(200, 200, 60);
    send_rand(10);
    drain();

    done = 1;
    finish_run();
  end

endmodule